// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write a 256K x 8 asynchronous static RAM that has a pair of chip selects (one active low, one active high), an active-low output enable and an active-low write enable. The host issues a single-cycle request strobe carrying an 18-bit address, a direction flag and 8-bit write data. The controller then runs the memory pins through a timed sequence and returns a one-clock acknowledge. On a read, the captured byte is presented with that acknowledge.

All memory timing minimums are parameters in nanoseconds, next to a clock-period parameter. Each minimum becomes a cycle count equal to the ceiling of the minimum divided by the period, and never less than one cycle. Writes are controlled by the write-enable pulse. Output enable stays high for the whole write. The controller's own data driver, which enables an external tristate buffer, is switched on only after write enable has fallen and switched off only after it has risen again. After every read a deselected turnaround period runs before any new access can begin.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the active-low select is 1, the active-high select is 0, write and output enables are 1, the data drive enable is 0 and the acknowledge is 0.
- R2: The memory is selected only as the pair (active-low select 0, active-high select 1), and whenever write enable or output enable is low. At every other time the pair is (1, 0).
- R3: A read holds output enable low and write enable high with the chip selected for RD cycles, where RD is the larger of the ceiling of access time over period and the ceiling of output-enable time over period (14 with defaults). The input byte is captured on the last of these cycles.
- R4: A write keeps output enable high throughout. It holds the address for one selected cycle before write enable falls. Write enable stays low for P cycles, where P is the largest of the ceiling of the pulse width, the data setup ceiling plus one, the address-to-end ceiling minus one, and 2 (P is 12 with defaults).
- R5: Data drive enable rises exactly one cycle after write enable falls and falls exactly one cycle after write enable rises.
- R6: Counted from the accepting clock edge to the acknowledge cycle, a write lasts at least the write-cycle count. With defaults the acknowledge appears in the 16th cycle after acceptance.
- R7: After a read, the chip stays deselected for at least the high-impedance turnaround count (7 with defaults) before the next access. The data drive is never on while output enable is low.
- R8: A request strobe seen while a transfer or turnaround is in progress is ignored and starts no memory access.
- R9: Address, direction and write data are latched at acceptance. The memory address is stable for as long as the chip stays selected, and later changes on the host inputs have no effect on the current transfer.
- R10: Every cycle count is the ceiling of the nanosecond minimum divided by the clock period, and at least one.
- R11: The acknowledge is one clock long. For a read it appears in cycle RD+1 after acceptance, together with the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Request address |
| req_wdata_i | input | 8 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read byte |
| mem_addr_o | output | 18 | Memory address |
| mem_ce_n_o | output | 1 | Active-low chip select |
| mem_ce_o | output | 1 | Active-high chip select |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the external data buffer |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The hardest situation to reach is a request that arrives while the controller is busy. This covers the strobe landing mid-write and a write that is already pending when a read's turnaround period ends. The bench reaches the first case by pulsing a read strobe several cycles into a write and then watching the select pins after the acknowledge. It reaches the second by holding the strobe high from the read acknowledge onward, which measures the deselected gap before the write begins. A memory model in the bench commits bytes on the rising edge of write enable. This lets the bench read back mid-transfer changes to the host inputs and see that they had no effect.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_LOW,
    ST_W_DRIVE,
    ST_W_HOLD,
    ST_W_REC,
    ST_R_ACCESS,
    ST_R_TURN
  } phase_e;

  // ceiling of ns / period, never below one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  // counter parks at zero until reloaded (R10)
  p_timer_park_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> cnt_q == '0);

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= mem_dq_i;
  end

  // latched request never changes without an accept (R9)
  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(addr_o) && $stable(wdata_o));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned PULSE_C = 2,
  parameter int unsigned REC_C   = 1,
  parameter int unsigned RD_C    = 1,
  parameter int unsigned TURN_C  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_write_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output phase_e           state_d_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ack_o
);

  localparam logic [CNT_W-1:0] LD_DRIVE = CNT_W'(PULSE_C - 2);
  localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(REC_C - 1);
  localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_C - 1);

  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i) state_d = req_write_i ? ST_W_SETUP : ST_R_ACCESS;
      ST_W_SETUP:  if (last_i) state_d = ST_W_LOW;
      ST_W_LOW:    state_d = ST_W_DRIVE;
      ST_W_DRIVE:  if (last_i) state_d = ST_W_HOLD;
      ST_W_HOLD:   state_d = ST_W_REC;
      ST_W_REC:    if (last_i) state_d = ST_IDLE;
      ST_R_ACCESS: if (last_i) state_d = ST_R_TURN;
      ST_R_TURN:   if (last_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_W_DRIVE:  load_val_o = LD_DRIVE;
      ST_W_REC:    load_val_o = LD_REC;
      ST_R_ACCESS: load_val_o = LD_RD;
      ST_R_TURN:   load_val_o = LD_TURN;
      default:     load_val_o = '0;
    endcase
  end

  assign load_o    = (state_d != state_q);
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_R_ACCESS) && last_i;
  assign state_d_o = state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_o   <= capture_o || ((state_q == ST_W_REC) && last_i);
    end
  end

  // a transfer begins only from idle (R8)
  p_start_from_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_W_SETUP || (state_q == ST_R_ACCESS && $past(state_q) != ST_R_ACCESS))
      |-> $past(state_q) == ST_IDLE);

  // acknowledge is a single clock (R11)
  p_ack_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // read turnaround always follows a read access (R7)
  p_turn_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_R_ACCESS && last_i) |=> state_q == ST_R_TURN);

endmodule

// File: rtl/sram_pin_ctrl.sv
module sram_pin_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned PULSE_C = 2,
  parameter int unsigned CNT_W   = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e state_d_i,
  output logic   ce_n_o,
  output logic   ce_o,
  output logic   we_n_o,
  output logic   oe_n_o,
  output logic   dq_oe_o
);

  localparam int unsigned WCNT_W = CNT_W + 1;

  logic sel_d, we_d, oe_d, drv_d;

  always_comb begin
    sel_d = state_d_i inside {ST_W_SETUP, ST_W_LOW, ST_W_DRIVE, ST_W_HOLD, ST_R_ACCESS};
    we_d  = state_d_i inside {ST_W_LOW, ST_W_DRIVE};
    oe_d  = (state_d_i == ST_R_ACCESS);
    drv_d = state_d_i inside {ST_W_DRIVE, ST_W_HOLD};
  end

  // pins come straight from flops: no decode glitches reach the memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o  <= 1'b1;
      ce_o    <= 1'b0;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_n_o  <= !sel_d;
      ce_o    <= sel_d;
      we_n_o  <= !we_d;
      oe_n_o  <= !oe_d;
      dq_oe_o <= drv_d;
    end
  end

  logic [WCNT_W-1:0] wlow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wlow_q <= '0;
    else if (we_n_o) wlow_q <= '0;
    else             wlow_q <= wlow_q + 1'b1;
  end

  p_we_oe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !oe_n_o));

  p_we_pulse_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> wlow_q == WCNT_W'(PULSE_C));

  p_drv_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> !we_n_o && $past(!we_n_o));

  p_drv_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> we_n_o && $past(we_n_o));

  p_no_contention_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_n_o);

  p_strobe_selected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_o || !oe_n_o) |-> (!ce_n_o && ce_o));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 4,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_WP_NS   = 40,
  parameter int unsigned T_AW_NS   = 50,
  parameter int unsigned T_DW_NS   = 25,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_OE_NS   = 30,
  parameter int unsigned T_HZ_NS   = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned WC_C = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WP_C = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned AW_C = ns_to_cyc(T_AW_NS, CLK_NS);
  localparam int unsigned DW_C = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int unsigned AA_C = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int unsigned OE_C = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int unsigned HZ_C = ns_to_cyc(T_HZ_NS, CLK_NS);

  // one write-enable pulse covers pulse width, data setup and address-to-end
  localparam int unsigned PULSE_C = umax(umax(WP_C, DW_C + 1), umax(AW_C - 1, 2));
  localparam int unsigned REC_C   = (WC_C > PULSE_C + 2) ? (WC_C - PULSE_C - 2) : 1;
  localparam int unsigned RD_C    = umax(AA_C, OE_C);
  localparam int unsigned TURN_C  = HZ_C;
  localparam int unsigned MAX_C   = umax(umax(PULSE_C, REC_C), umax(RD_C, TURN_C));
  localparam int unsigned CNT_W   = $clog2(MAX_C + 1);

  logic             load, last, accept, capture;
  logic [CNT_W-1:0] load_val;
  phase_e           state_d;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_ctrl_fsm #(
    .CNT_W   (CNT_W),
    .PULSE_C (PULSE_C),
    .REC_C   (REC_C),
    .RD_C    (RD_C),
    .TURN_C  (TURN_C)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_write_i (req_write_i),
    .last_i      (last),
    .load_o      (load),
    .load_val_o  (load_val),
    .state_d_o   (state_d),
    .accept_o    (accept),
    .capture_o   (capture),
    .ack_o       (ack_o)
  );

  sram_pin_ctrl #(.PULSE_C(PULSE_C), .CNT_W(CNT_W)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .ce_n_o    (mem_ce_n_o),
    .ce_o      (mem_ce_o),
    .we_n_o    (mem_we_n_o),
    .oe_n_o    (mem_oe_n_o),
    .dq_oe_o   (mem_dq_oe_o)
  );

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .capture_i (capture),
    .mem_dq_i  (mem_dq_i),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .rdata_o   (rdata_o)
  );

  logic sel;
  assign sel = !mem_ce_n_o && mem_ce_o;

  p_addr_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && $past(sel)) |-> $stable(mem_addr_o));

  p_sel_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ce_n_o != mem_ce_o));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_NS = 4;

  function automatic int cdiv(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_RD    = imax(cdiv(55), cdiv(30));
  localparam int EXP_PULSE = imax(imax(cdiv(40), cdiv(25) + 1), imax(cdiv(50) - 1, 2));
  localparam int EXP_WC    = cdiv(55);
  localparam int EXP_REC   = (EXP_WC > EXP_PULSE + 2) ? EXP_WC - EXP_PULSE - 2 : 1;
  localparam int EXP_WACK  = EXP_PULSE + EXP_REC + 3;
  localparam int EXP_TURN  = cdiv(25);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ack;
  logic [7:0]  rdata;
  logic [17:0] m_addr;
  logic        m_ce_n, m_ce, m_we_n, m_oe_n, m_dq_oe;
  logic [7:0]  m_dq_o;
  logic [7:0]  m_dq_i = '0;

  int checks = 0, failures = 0, contention = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_write_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ack_o(ack), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_ce_n_o(m_ce_n), .mem_ce_o(m_ce), .mem_we_n_o(m_we_n),
    .mem_oe_n_o(m_oe_n), .mem_dq_o(m_dq_o), .mem_dq_oe_o(m_dq_oe), .mem_dq_i(m_dq_i)
  );

  // memory model: commit on rising write enable, drive read data while output enabled
  logic [7:0] mem [int];
  logic we_prev = 1'b1;
  always @(negedge clk) begin
    if (m_we_n && !we_prev && !m_ce_n && m_ce && m_dq_oe) mem[int'(m_addr)] = m_dq_o;
    we_prev = m_we_n;
    if (!m_ce_n && m_ce && !m_oe_n && m_we_n)
      m_dq_i = mem.exists(int'(m_addr)) ? mem[int'(m_addr)] : 8'hEE;
    else
      m_dq_i = 8'h00;
    if (m_dq_oe && !m_oe_n) contention++;
  end

  task automatic chk(bit ok, string req_tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic bit sel_now();
    return !m_ce_n && m_ce;
  endfunction

  task automatic t_reset();
    chk(m_ce_n && !m_ce, "R1 select pair idle", {m_ce_n, m_ce}, 2);
    chk(m_we_n && m_oe_n, "R1 strobes high", {m_we_n, m_oe_n}, 3);
    chk(!m_dq_oe && !ack, "R1 drive/ack off", {m_dq_oe, ack}, 0);
  endtask

  task automatic t_write(input logic [17:0] a, input logic [7:0] d, input int glitch_k);
    int we_cnt = 0, fw = 0, lw = 0, fd = 0, ld = 0, ack_k = 0, oe_seen = 0, bad_pair = 0, first_sel = 0;
    @(negedge clk);
    req = 1; req_wr = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    for (int k = 1; k < 64; k++) begin
      if (k == glitch_k) begin req_addr = a ^ 18'h1; req_wdata = ~d; end
      if (sel_now() && first_sel == 0) first_sel = k;
      if (!m_we_n) begin we_cnt++; if (fw == 0) fw = k; lw = k; end
      if (m_dq_oe) begin if (fd == 0) fd = k; ld = k; end
      if (!m_oe_n) oe_seen++;
      if (m_ce_n == m_ce) bad_pair++;
      if (!m_we_n && !sel_now()) bad_pair++;
      if (ack) begin ack_k = k; break; end
      @(negedge clk);
    end
    chk(oe_seen == 0, "R4 oe high in write", oe_seen, 0);
    chk(fw == first_sel + 1, "R4 address setup cycle", fw, first_sel + 1);
    chk(we_cnt == EXP_PULSE, "R4 R10 we low cycles", we_cnt, EXP_PULSE);
    chk(fd == fw + 1, "R5 drive on after we low", fd, fw + 1);
    chk(ld == lw + 1, "R5 drive off after we high", ld, lw + 1);
    chk(ack_k == EXP_WACK && ack_k - 1 >= EXP_WC, "R6 write ack cycle", ack_k, EXP_WACK);
    chk(bad_pair == 0, "R2 select pair", bad_pair, 0);
    @(negedge clk);
    chk(!ack, "R11 write ack one cycle", ack, 0);
  endtask

  task automatic t_read(input logic [17:0] a, input logic [7:0] exp, output int ack_k);
    int oe_cnt = 0, bad = 0;
    ack_k = 0;
    @(negedge clk);
    req = 1; req_wr = 0; req_addr = a;
    @(negedge clk);
    req = 0;
    for (int k = 1; k < 64; k++) begin
      if (!m_oe_n) begin oe_cnt++; if (!sel_now() || !m_we_n) bad++; end
      if (ack) begin ack_k = k; break; end
      @(negedge clk);
    end
    chk(oe_cnt == EXP_RD, "R3 R10 oe low cycles", oe_cnt, EXP_RD);
    chk(bad == 0, "R2 R3 selected with we high", bad, 0);
    chk(ack_k == EXP_RD + 1, "R11 read ack cycle", ack_k, EXP_RD + 1);
    chk(rdata == exp, "R3 read data", rdata, exp);
  endtask

  task automatic t_patterns();
    int ak;
    t_write(18'h00000, 8'h00, 0);
    t_write(18'h3FFFF, 8'hFF, 0);
    t_write(18'h15555, 8'hA5, 0);
    t_read(18'h3FFFF, 8'hFF, ak);
    @(negedge clk);
    chk(!ack, "R11 read ack one cycle", ack, 0);
    repeat (EXP_TURN) @(negedge clk);
    t_read(18'h15555, 8'hA5, ak);
    repeat (EXP_TURN) @(negedge clk);
    t_read(18'h00000, 8'h00, ak);
    repeat (EXP_TURN) @(negedge clk);
  endtask

  task automatic t_busy_ignored();
    int act = 0, ak;
    fork
      t_write(18'h00100, 8'h3C, 0);
      begin
        repeat (6) @(negedge clk);
        req = 1; req_wr = 0; req_addr = 18'h00200;
        @(negedge clk);
        req = 0;
      end
    join
    for (int k = 0; k < 10; k++) begin
      if (sel_now()) act++;
      @(negedge clk);
    end
    chk(act == 0, "R8 busy request ignored", act, 0);
    t_read(18'h00100, 8'h3C, ak);
    repeat (EXP_TURN) @(negedge clk);
  endtask

  task automatic t_latch();
    int ak;
    t_write(18'h00400, 8'h5A, 4);
    t_read(18'h00400, 8'h5A, ak);
    repeat (EXP_TURN) @(negedge clk);
    t_read(18'h00401, 8'hEE, ak);
    chk(rdata == 8'hEE, "R9 neighbour untouched", rdata, 8'hEE);
    repeat (EXP_TURN) @(negedge clk);
  endtask

  task automatic t_turnaround();
    int ak, gap = 0;
    t_read(18'h00400, 8'h5A, ak);
    req = 1; req_wr = 1; req_addr = 18'h00500; req_wdata = 8'h77;
    for (int k = 0; k < 64; k++) begin
      if (sel_now()) break;
      gap++;
      @(negedge clk);
    end
    req = 0;
    chk(gap >= EXP_TURN && gap == EXP_TURN + 1, "R7 read turnaround gap", gap, EXP_TURN + 1);
    for (int k = 0; k < 64; k++) begin
      if (ack) break;
      @(negedge clk);
    end
    @(negedge clk);
    t_read(18'h00500, 8'h77, ak);
    repeat (EXP_TURN) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_patterns();
    t_busy_ignored();
    t_latch();
    t_turnaround();
    chk(contention == 0, "R7 no bus contention", contention, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule